// File: doc/BRIEF.md
# Run-Time Depth-Switching Pipeline

This block is an in-order pipeline shell whose depth can be changed while the chip runs. In its deep setting, every token crosses seven registers. In its shallow setting, two of those registers become transparent. The stage pairs on either side of each transparent register then act as one stage, and a token crosses five registers. The stage logic itself is a placeholder: each token's data word leaves exactly as it entered. Surrounding logic is expected to fill in the real per-stage work later.

A small mode controller owns the depth setting. When a request asks for the other depth, the controller stops taking new input and waits until no stage holds a valid token. Only then does it swap the bypass pattern, acknowledge, and reopen the input. The whole exchange costs a handful of cycles plus the drain time, so it fits inside a task switch. A request for the depth already in force is acknowledged at once, without disturbing the flow.

Top module: `depth_switch_pipe`

## Requirements
- R1: After reset the pipeline is in the seven-register mode (`mode_short` = 0), `out_valid` and `mode_ack` are 0 and `in_ready` is 1.
- R2: In seven-register mode, a token accepted in cycle n (`in_valid` and `in_ready` both 1) appears on `out_valid`/`out_data` in cycle n+7 with its data unchanged.
- R3: In five-register mode (`mode_short` = 1) the registers after stage 2 and after stage 5 are transparent. A token accepted in cycle n appears in cycle n+5 with its data unchanged.
- R4: A request (`mode_req_valid` = 1) whose `mode_req_short` differs from `mode_short` causes `in_ready` to drop in the next cycle. `in_ready` stays low until the change is acknowledged, and it is still low in the acknowledge cycle.
- R5: The depth changes only while no stage holds a valid token. Every accepted token leaves exactly once and in acceptance order, also across a depth change.
- R6: A request equal to the current mode is acknowledged with a one-cycle `mode_ack` pulse in the next cycle. `in_ready` stays 1 and the mode is unchanged.
- R7: Requests arriving while a change is in progress are ignored: they produce no acknowledge and no further mode change.
- R8: For a depth change requested in cycle r, with the last in-flight token leaving in cycle X, `mode_ack` pulses in cycle max(r, X)+3. `mode_short` shows the new mode in that cycle, and `in_ready` returns to 1 one cycle later.
- R9: In either mode, while no change is pending, the pipeline accepts one token per cycle with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input token present |
| in_data | input | DATA_W | Input token payload (tag and sequence) |
| in_ready | output | 1 | Pipeline accepts a token this cycle |
| out_valid | output | 1 | Output token present |
| out_data | output | DATA_W | Output token payload |
| mode_req_valid | input | 1 | Depth change request strobe |
| mode_req_short | input | 1 | Requested mode: 1 = five-register, 0 = seven-register |
| mode_ack | output | 1 | One-cycle acknowledge of a served request |
| mode_short | output | 1 | Mode in force: 1 = five-register, 0 = seven-register |

## Verification
A wrong bypass pattern shows at the output within one pipeline traversal, as a token arriving two cycles early or late. A controller that switches before the drain ends shows up as a token whose arrival cycle matches neither depth. A stuck or skipped controller state shows as an acknowledge that arrives at the wrong cycle or never arrives, or as `in_ready` staying low past the expected resume cycle. Both of these are visible within a few cycles of the request. Lost, duplicated or reordered tokens are caught at the very next output, because each output is matched in order against the payload and cycle expected from its acceptance.

// File: rtl/vdp_pkg.sv
package vdp_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_SWITCH = 2'd2,
        ST_RESUME = 2'd3
    } vdp_state_e;

    typedef struct packed {
        vdp_state_e state;
        logic       short_mode;
        logic       target;
        logic       ack;
    } vdp_ctrl_t;

endpackage

// File: rtl/vdp_stage_reg.sv
module vdp_stage_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bypass,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              q_valid,
    output logic [DATA_W-1:0] q_data
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    // Placeholder stage work: payload passes through untouched.
    // A transparent register never holds a token, so its valid stays clear.
    always_comb begin
        slot_d       = slot_q;
        slot_d.valid = in_valid & ~bypass;
        slot_d.data  = bypass ? '0 : in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign q_valid = slot_q.valid;
    assign q_data  = slot_q.data;
endmodule

// File: rtl/vdp_stage_chain.sv
module vdp_stage_chain #(
    parameter int                DATA_W     = 16,
    parameter int                STAGES     = 7,
    parameter logic [STAGES-1:0] SHORT_MASK = 7'b0010010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              short_mode,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [STAGES-1:0] stage_busy
);
    logic              link_v [STAGES+1];
    logic [DATA_W-1:0] link_d [STAGES+1];

    assign link_v[0] = in_valid;
    assign link_d[0] = in_data;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic              byp;
        logic              q_v;
        logic [DATA_W-1:0] q_d;

        assign byp = short_mode & SHORT_MASK[k];

        vdp_stage_reg #(.DATA_W(DATA_W)) u_reg (
            .clk      (clk),
            .rst      (rst),
            .bypass   (byp),
            .in_valid (link_v[k]),
            .in_data  (link_d[k]),
            .q_valid  (q_v),
            .q_data   (q_d)
        );

        // A transparent register merges its neighbours into one stage.
        assign link_v[k+1]   = byp ? link_v[k] : q_v;
        assign link_d[k+1]   = byp ? link_d[k] : q_d;
        assign stage_busy[k] = q_v;
    end

    assign out_valid = link_v[STAGES];
    assign out_data  = link_d[STAGES];
endmodule

// File: rtl/vdp_mode_ctrl.sv
module vdp_mode_ctrl
    import vdp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_short,
    input  logic       pipe_busy,
    output logic       accept_en,
    output logic       short_mode,
    output logic       ack,
    output vdp_state_e state
);
    vdp_ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ack = 1'b0;
        unique case (ctl_q.state)
            ST_RUN: begin
                if (req_valid) begin
                    if (req_short == ctl_q.short_mode) begin
                        ctl_d.ack = 1'b1;
                    end else begin
                        ctl_d.target = req_short;
                        ctl_d.state  = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                if (!pipe_busy) begin
                    ctl_d.state = ST_SWITCH;
                end
            end
            ST_SWITCH: begin
                ctl_d.short_mode = ctl_q.target;
                ctl_d.ack        = 1'b1;
                ctl_d.state      = ST_RESUME;
            end
            ST_RESUME: begin
                ctl_d.state = ST_RUN;
            end
            default: ctl_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{state: ST_RUN, short_mode: 1'b0, target: 1'b0, ack: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign accept_en  = (ctl_q.state == ST_RUN);
    assign short_mode = ctl_q.short_mode;
    assign ack        = ctl_q.ack;
    assign state      = ctl_q.state;
endmodule

// File: rtl/depth_switch_pipe.sv
module depth_switch_pipe
    import vdp_pkg::*;
#(
    parameter int                DATA_W     = 16,
    parameter int                STAGES     = 7,
    parameter logic [STAGES-1:0] SHORT_MASK = 7'b0010010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              mode_req_valid,
    input  logic              mode_req_short,
    output logic              mode_ack,
    output logic              mode_short
);
    logic [STAGES-1:0] stage_busy;
    logic              pipe_busy;
    logic              take;
    vdp_state_e        ctrl_state;

    assign pipe_busy = |stage_busy;
    assign take      = in_valid & in_ready;

    vdp_mode_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (mode_req_valid),
        .req_short  (mode_req_short),
        .pipe_busy  (pipe_busy),
        .accept_en  (in_ready),
        .short_mode (mode_short),
        .ack        (mode_ack),
        .state      (ctrl_state)
    );

    vdp_stage_chain #(
        .DATA_W     (DATA_W),
        .STAGES     (STAGES),
        .SHORT_MASK (SHORT_MASK)
    ) u_chain (
        .clk        (clk),
        .rst        (rst),
        .short_mode (mode_short),
        .in_valid   (take),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .stage_busy (stage_busy)
    );
endmodule

// File: rtl/depth_switch_pipe_chk.sv
module depth_switch_pipe_chk
    import vdp_pkg::*;
#(
    parameter int                STAGES     = 7,
    parameter logic [STAGES-1:0] SHORT_MASK = 7'b0010010
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              out_valid,
    input logic              mode_req_valid,
    input logic              mode_req_short,
    input logic              mode_ack,
    input logic              mode_short,
    input logic [STAGES-1:0] stage_busy,
    input vdp_state_e        ctrl_state
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!mode_short && !out_valid && in_ready && !mode_ack));

    // R3
    short_bypass_empty_chk: assert property (@(posedge clk) disable iff (rst)
        mode_short |-> ((stage_busy & SHORT_MASK) == '0));

    // R4
    drain_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_state != ST_RUN) |-> !in_ready);

    // R5
    mode_flip_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_short != $past(mode_short)) |-> ($past(stage_busy) == '0));

    // R6
    same_mode_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && mode_req_valid && (mode_req_short == mode_short))
        |=> (mode_ack && in_ready && $stable(mode_short)));

    // R7
    ack_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        mode_ack |-> (($past(ctrl_state) == ST_SWITCH) || $past(mode_req_valid && in_ready)));
endmodule

bind depth_switch_pipe depth_switch_pipe_chk #(
    .STAGES     (STAGES),
    .SHORT_MASK (SHORT_MASK)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .mode_req_valid (mode_req_valid),
    .mode_req_short (mode_req_short),
    .mode_ack       (mode_ack),
    .mode_short     (mode_short),
    .stage_busy     (stage_busy),
    .ctrl_state     (ctrl_state)
);

// File: tb/depth_switch_pipe_test.sv
module depth_switch_pipe_test;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          mode_req_valid = 1'b0;
    logic          mode_req_short = 1'b0;
    logic          mode_ack;
    logic          mode_short;

    always #10 clk = ~clk;

    depth_switch_pipe #(.DATA_W(DW)) uut (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .in_data        (in_data),
        .in_ready       (in_ready),
        .out_valid      (out_valid),
        .out_data       (out_data),
        .mode_req_valid (mode_req_valid),
        .mode_req_short (mode_req_short),
        .mode_ack       (mode_ack),
        .mode_short     (mode_short)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_exp = -100;
    int req_total = 0;
    int ack_total = 0;
    int seq = 0;
    logic model_short = 1'b0;
    bit done = 0;

    int exp_data_q[$];
    int exp_cyc_q[$];
    bit exp_short_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Output monitor: every token compared in order against payload and arrival cycle.
    always @(negedge clk) begin
        if (!rst) begin
            if (mode_ack) ack_total++;
            if (out_valid) begin
                if (exp_data_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected output", int'(out_data), -1);
                end else begin
                    int ed, ec;
                    bit es;
                    ed = exp_data_q.pop_front();
                    ec = exp_cyc_q.pop_front();
                    es = exp_short_q.pop_front();
                    chk(int'(out_data) == ed, "R5 order/data", int'(out_data), ed);
                    chk(cyc == ec, es ? "R3 latency" : "R2 latency", cyc, ec);
                end
            end
        end
    end

    task automatic send_tok(input bit expect_ready);
        int lat, ec;
        seq++;
        in_valid = 1'b1;
        in_data  = DW'(16'h1000 + seq);
        if (expect_ready) chk(in_ready == 1'b1, "R9 throughput", int'(in_ready), 1);
        while (!in_ready) @(negedge clk);
        lat = model_short ? 5 : 7;
        ec  = cyc + lat;
        exp_data_q.push_back(int'(in_data));
        exp_cyc_q.push_back(ec);
        exp_short_q.push_back(model_short);
        if (ec > last_exp) last_exp = ec;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_req(input logic s);
        int r, want, waited;
        bit same;
        r    = cyc;
        same = (s == model_short);
        mode_req_valid = 1'b1;
        mode_req_short = s;
        @(negedge clk);
        mode_req_valid = 1'b0;
        req_total++;
        if (same) want = r + 1;
        else      want = ((r > last_exp) ? r : last_exp) + 3;
        if (!same) chk(in_ready == 1'b0, "R4 ready drop", int'(in_ready), 0);
        waited = 0;
        while (!mode_ack && waited < 60) begin
            @(negedge clk);
            waited++;
        end
        if (same) begin
            chk(mode_ack && cyc == want, "R6 ack timing", cyc, want);
            chk(in_ready == 1'b1, "R6 ready kept", int'(in_ready), 1);
            chk(mode_short == s, "R6 mode kept", int'(mode_short), int'(s));
        end else begin
            chk(mode_ack && cyc == want, "R8 ack timing", cyc, want);
            chk(in_ready == 1'b0, "R4 ready low at ack", int'(in_ready), 0);
            chk(mode_short == s, "R8 new mode", int'(mode_short), int'(s));
        end
        model_short = s;
        @(negedge clk);
        chk(in_ready == 1'b1, "R8 resume", int'(in_ready), 1);
    endtask

    // Vector: {short mode, burst length[3:0], gap cycles[1:0]}
    localparam logic [6:0] VEC [6] = '{
        {1'b0, 4'd4, 2'd0},
        {1'b1, 4'd5, 2'd0},
        {1'b1, 4'd3, 2'd1},
        {1'b0, 4'd6, 2'd2},
        {1'b0, 4'd2, 2'd0},
        {1'b1, 4'd8, 2'd0}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(mode_short == 1'b0, "R1 mode", int'(mode_short), 0);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(mode_ack == 1'b0, "R1 mode_ack", int'(mode_ack), 0);

        for (int i = 0; i < 6; i++) begin
            logic s;
            int n, g;
            s = VEC[i][6];
            n = int'(VEC[i][5:2]);
            g = int'(VEC[i][1:0]);
            do_req(s);
            for (int j = 0; j < n; j++) begin
                send_tok(1'b1);
                for (int k = 0; k < g; k++) @(negedge clk);
            end
        end

        // R7: second request during drain is ignored
        send_tok(1'b1);
        send_tok(1'b1);
        send_tok(1'b1);
        begin
            int r, want, waited;
            r = cyc;
            mode_req_valid = 1'b1;
            mode_req_short = 1'b0;
            @(negedge clk);
            req_total++;
            chk(in_ready == 1'b0, "R4 ready drop", int'(in_ready), 0);
            mode_req_short = 1'b1;
            @(negedge clk);
            mode_req_valid = 1'b0;
            want = ((r > last_exp) ? r : last_exp) + 3;
            waited = 0;
            while (!mode_ack && waited < 60) begin
                @(negedge clk);
                waited++;
            end
            chk(mode_ack && cyc == want, "R8 ack timing", cyc, want);
            model_short = 1'b0;
            repeat (8) @(negedge clk);
            chk(mode_short == 1'b0, "R7 mode after ignored req", int'(mode_short), 0);
        end
        send_tok(1'b1);
        send_tok(1'b1);

        repeat (15) @(negedge clk);
        chk(exp_data_q.size() == 0, "R5 all tokens out", exp_data_q.size(), 0);
        chk(ack_total == req_total, "R7 ack count", ack_total, req_total);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end
endmodule